// File: doc/BRIEF.md
# DMA Write Handshake Buffer Loader

This block is the peripheral end of a DMA write channel. An external DMA controller pushes bytes over a shared 8-bit processor data bus into one of several transmit packet buffers. A `start` pulse latches a channel number and a transfer length, and the block raises its request `dreq`. Once the controller answers with the active-low acknowledge `dack_n`, every low pulse of the active-low write strobe `wr_n` places one byte into the next location of the chosen buffer. The write goes out through a per-channel write-enable vector, a location and a data byte.

The strobe, the acknowledge and the data bus all arrive from outside the clock domain. Each passes through a two-stage synchroniser. A byte is committed when the synchronised strobe returns high, so one pulse is never counted twice.

The block ends the burst from its own side. When the strobe for the final byte goes low, `dreq` is withdrawn while that strobe is still low, and the byte is still written. The block then waits for the controller to confirm the end by releasing `dack_n` high. At that point it emits a one-cycle `done` pulse carrying the number of bytes written, and it accepts a new `start`.

Top module: `dmaw_loader`

## Requirements
- R1: A `start` pulse while idle and while `dack_n` is high raises `dreq` in the next cycle. `dreq` stays high until the final byte's strobe. A `start` while `dack_n` is low does not raise `dreq`.
- R2: Low pulses of `wr_n` whose falling edge arrives while `dack_n` is high produce no buffer write.
- R3: Each low pulse of `wr_n` that begins while `dack_n` is low produces exactly one write. The locations are 0, 1, 2, … in order. The data is the `dbus` value held during the low phase. The write enable is high for one cycle, three cycles after `wr_n` returns high.
- R4: Three cycles after `wr_n` falls for the final byte, `dreq` drops while `wr_n` is still low. That final byte is still written.
- R5: A `xfer_len` of 1 to DEPTH moves exactly that many bytes. A `xfer_len` of 0, or one above DEPTH, moves DEPTH bytes, which fills the buffer.
- R6: `buf_we` is one-hot: only bit k is set, where k is the `chan_sel` value latched at `start`. Changing `chan_sel` during a transfer has no effect.
- R7: After the final byte, and until the controller releases `dack_n`, further strobes are not captured and `start` is ignored.
- R8: `done` is high for exactly one cycle, three cycles after `dack_n` returns high at the end of a transfer. In that cycle `done_count` equals the number of bytes written.
- R9: During and just after reset, `dreq`, `buf_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| chan_sel | input | $clog2(NCH) | Buffer channel, latched at start |
| xfer_len | input | $clog2(DEPTH)+1 | Byte count, latched at start |
| dreq | output | 1 | DMA request |
| dack_n | input | 1 | DMA acknowledge, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| dbus | input | DATA_W | Shared data bus |
| buf_we | output | NCH | Per-channel buffer write enable |
| buf_addr | output | $clog2(DEPTH) | Buffer location |
| buf_data | output | DATA_W | Byte to write |
| done | output | 1 | End-of-transfer pulse |
| done_count | output | $clog2(DEPTH)+1 | Bytes moved, valid with done |

## Verification
Every asynchronous input passes through two synchroniser flops and then one output register. A `wr_n` rise, a `wr_n` fall or a `dack_n` rise therefore shows at the outputs three cycles after the bench drives it. A `start` pulse shows one cycle later. The bench drives and samples on the falling clock edge and counts these cycles exactly. At every cycle of a strobe it checks whether a write should be present, and which one. It checks the request level both on the cycle before the drop and on the cycle of the drop. The `done` pulse is checked on the cycle before it, on its own cycle and on the cycle after.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_TAIL   = 2'd2,
        ST_CLOSE  = 2'd3
    } dmaw_state_e;
endpackage

// File: rtl/dmaw_sync.sv
module dmaw_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dmaw_onehot.sv
module dmaw_onehot #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [W-1:0] idx,
    input  logic         en,
    output logic [N-1:0] hot
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign hot[g] = en && (idx == W'(g));
    end
endmodule

// File: rtl/dmaw_loader.sv
module dmaw_loader
    import dmaw_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [$clog2(NCH)-1:0]     chan_sel,
    input  logic [$clog2(DEPTH):0]     xfer_len,
    output logic                       dreq,
    input  logic                       dack_n,
    input  logic                       wr_n,
    input  logic [DATA_W-1:0]          dbus,
    output logic [NCH-1:0]             buf_we,
    output logic [$clog2(DEPTH)-1:0]   buf_addr,
    output logic [DATA_W-1:0]          buf_data,
    output logic                       done,
    output logic [$clog2(DEPTH):0]     done_count
);
    localparam int CH_W   = $clog2(NCH);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int LEN_W  = ADDR_W + 1;
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DEPTH);

    typedef struct packed {
        dmaw_state_e         st;
        logic [CH_W-1:0]     ch;
        logic [ADDR_W-1:0]   last;
        logic [LEN_W-1:0]    ptr;
        logic                armed;
        logic                wr_prev;
        logic [DATA_W-1:0]   hold;
        logic                req;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic                done;
        logic [LEN_W-1:0]    dcount;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:      ST_IDLE,
        ch:      '0,
        last:    '0,
        ptr:     '0,
        armed:   1'b0,
        wr_prev: 1'b1,
        hold:    '0,
        req:     1'b0,
        we:      1'b0,
        addr:    '0,
        data:    '0,
        done:    1'b0,
        dcount:  '0
    };

    regs_t r_d, r_q;

    // synchronised strobe, acknowledge and data bus
    logic              wr_s;
    logic              dack_s;
    logic [DATA_W-1:0] data_s;
    logic              ack_act;

    dmaw_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dack_n, wr_n}),
        .q     ({dack_s, wr_s})
    );

    dmaw_sync #(.W(DATA_W), .STAGES(2), .RST_VAL('0)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dbus),
        .q     (data_s)
    );

    assign ack_act = ~dack_s;

    logic              strobe_fall;
    logic              strobe_rise;
    logic [LEN_W-1:0]  len_eff;
    logic              at_last;

    always_comb begin
        r_d         = r_q;
        r_d.we      = 1'b0;
        r_d.done    = 1'b0;
        r_d.wr_prev = wr_s;

        strobe_fall = r_q.wr_prev & ~wr_s;
        strobe_rise = ~r_q.wr_prev & wr_s;

        if ((xfer_len == '0) || (xfer_len > FULL_LEN)) len_eff = FULL_LEN;
        else                                           len_eff = xfer_len;

        at_last = (r_q.ptr[ADDR_W-1:0] == r_q.last);

        // track the bus value while the strobe is low
        if (!wr_s) r_d.hold = data_s;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start && !ack_act) begin
                    r_d.st    = ST_ACTIVE;
                    r_d.ch    = chan_sel;
                    r_d.last  = ADDR_W'(len_eff - LEN_W'(1));
                    r_d.ptr   = '0;
                    r_d.armed = 1'b0;
                    r_d.req   = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (strobe_fall && ack_act) begin
                    r_d.armed = 1'b1;
                    if (at_last) begin
                        r_d.st  = ST_TAIL;
                        r_d.req = 1'b0;
                    end
                end
                if (strobe_rise && r_q.armed) begin
                    r_d.we    = 1'b1;
                    r_d.addr  = r_q.ptr[ADDR_W-1:0];
                    r_d.data  = r_q.hold;
                    r_d.ptr   = r_q.ptr + LEN_W'(1);
                    r_d.armed = 1'b0;
                end
            end
            ST_TAIL: begin
                if (strobe_rise && r_q.armed) begin
                    r_d.we    = 1'b1;
                    r_d.addr  = r_q.ptr[ADDR_W-1:0];
                    r_d.data  = r_q.hold;
                    r_d.ptr   = r_q.ptr + LEN_W'(1);
                    r_d.armed = 1'b0;
                    r_d.st    = ST_CLOSE;
                end
            end
            ST_CLOSE: begin
                if (!ack_act) begin
                    r_d.done   = 1'b1;
                    r_d.dcount = r_q.ptr;
                    r_d.st     = ST_IDLE;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    dmaw_onehot #(.N(NCH), .W(CH_W)) u_we_dec (
        .idx (r_q.ch),
        .en  (r_q.we),
        .hot (buf_we)
    );

    assign dreq       = r_q.req;
    assign buf_addr   = r_q.addr;
    assign buf_data   = r_q.data;
    assign done       = r_q.done;
    assign done_count = r_q.dcount;
endmodule

module dmaw_loader_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dreq,
    input logic           ack_act,
    input logic           wr_s,
    input logic [NCH-1:0] buf_we,
    input logic           done
);
    // R1
    dreq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dreq) |-> $past(!ack_act));

    // R4
    dreq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dreq) |-> $past(!wr_s));

    // R6
    we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_we));

    // R3
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we != '0) |=> (buf_we == '0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dreq && $past(!ack_act)));
endmodule

bind dmaw_loader dmaw_loader_chk #(.NCH(NCH)) u_loader_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dreq    (dreq),
    .ack_act (ack_act),
    .wr_s    (wr_s),
    .buf_we  (buf_we),
    .done    (done)
);

// File: tb/test_dmaw_loader.sv
module test_dmaw_loader;
    localparam int NCH    = 4;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 8;
    localparam int CH_W   = $clog2(NCH);
    localparam int ADDR_W = $clog2(DEPTH);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [CH_W-1:0]    chan_sel = '0;
    logic [ADDR_W:0]    xfer_len = '0;
    logic               dreq;
    logic               dack_n = 1'b1;
    logic               wr_n = 1'b1;
    logic [DATA_W-1:0]  dbus = '0;
    logic [NCH-1:0]     buf_we;
    logic [ADDR_W-1:0]  buf_addr;
    logic [DATA_W-1:0]  buf_data;
    logic               done;
    logic [ADDR_W:0]    done_count;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dmaw_loader #(.NCH(NCH), .DEPTH(DEPTH), .DATA_W(DATA_W)) i_dmaw_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
        .xfer_len(xfer_len), .dreq(dreq), .dack_n(dack_n), .wr_n(wr_n),
        .dbus(dbus), .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .done(done), .done_count(done_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pattern(input int ch, input int len, input int i);
        return 8'((ch * 53 + len * 7 + i * 29 + 5) & 255);
    endfunction

    // strobe that must be captured: byte number idx of a transfer on channel ch
    task automatic strobe_take(input logic [7:0] b, input bit is_last, input int ch, input int idx);
        @(negedge clk); dbus = b; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(dreq == 1'b1, "R4 request held before final strobe seen", int'(dreq), 1);
        @(negedge clk);
        if (is_last) check(dreq == 1'b0, "R4 request dropped during final strobe", int'(dreq), 0);
        else         check(dreq == 1'b1, "R1 request held mid transfer", int'(dreq), 1);
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); dbus = ~b;
        @(negedge clk);
        check(buf_we == '0, "R3 no write before third cycle", int'(buf_we), 0);
        @(negedge clk);
        check(buf_we == NCH'(1 << ch), "R6 write enable channel", int'(buf_we), 1 << ch);
        check(int'(buf_addr) == idx, "R3 write location", int'(buf_addr), idx);
        check(buf_data == b, "R3 write data", int'(buf_data), int'(b));
        @(negedge clk);
        check(buf_we == '0, "R3 single write pulse", int'(buf_we), 0);
    endtask

    // strobe that must not be captured
    task automatic strobe_drop(input string tag);
        bit seen = 1'b0;
        @(negedge clk); dbus = 8'hA5; wr_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (buf_we != '0) seen = 1'b1;
        end
        wr_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (buf_we != '0) seen = 1'b1;
        end
        check(!seen, tag, int'(seen), 0);
    endtask

    task automatic run_xfer(input int ch, input int len);
        int nb;
        nb = (len == 0 || len > DEPTH) ? DEPTH : len;
        @(negedge clk);
        chan_sel = CH_W'(ch); xfer_len = (ADDR_W+1)'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chan_sel = CH_W'(ch + 1);
        check(dreq == 1'b1, "R1 request raised after start", int'(dreq), 1);
        if (len % 2 == 1) begin
            strobe_drop("R2 strobe without acknowledge ignored");
            check(dreq == 1'b1, "R2 request kept after ignored strobe", int'(dreq), 1);
        end
        dack_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nb; i++)
            strobe_take(pattern(ch, len, i), i == nb - 1, ch, i);
        if (ch == 2) strobe_drop("R7 strobe after final byte ignored");
        if (ch == 1) begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            @(negedge clk);
            check(dreq == 1'b0, "R7 start ignored before release", int'(dreq), 0);
        end
        @(negedge clk); dack_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, "R8 done not early", int'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R8 done on third cycle", int'(done), 1);
        check(int'(done_count) == nb, "R5 byte count", int'(done_count), nb);
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", int'(done), 0);
        check(dreq == 1'b0, "R1 no request after end", int'(dreq), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dreq == 1'b0 && done == 1'b0 && buf_we == '0, "R9 reset outputs low",
              int'({dreq, done, buf_we}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(dreq == 1'b0 && done == 1'b0 && buf_we == '0, "R9 idle after reset",
              int'({dreq, done, buf_we}), 0);

        // R1: start refused while acknowledge held low
        dack_n = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(dreq == 1'b0, "R1 start refused with acknowledge low", int'(dreq), 0);
        end
        dack_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5 sweep over every channel and lengths including 0 and above DEPTH
        for (int ch = 0; ch < NCH; ch++)
            for (int len = 0; len <= DEPTH + 2; len++)
                run_xfer(ch, len);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule